// File: doc/BRIEF.md
# Sub-Word Register Window Decoder

This block sits between a byte-addressed host port and three register targets that only understand whole 32-bit words: a SCSI core register bank, a DMA channel register bank and a single bus-and-control register. The host may read or write 1, 2, 3 or 4 bytes at any byte address inside a 128-byte window. The block works out which target the address falls in and translates the address into that target's word index. On a read it picks the addressed bytes out of the returned word. On a write it either passes the full word straight through or widens the access into a full word first.

A write that is narrower than a word, or that starts off a word boundary, becomes a read-merge-write. The block fetches the current word over a side-effect-free peek path: it drives the target index with the read strobe held low. It replaces only the addressed bytes, then issues one aligned 32-bit write. During the two cycles this takes, the host port is stalled. Reads raise the target's read strobe, so targets with clear-on-read status behave as normal. The merge fetch never raises that strobe.

Top module: `regwin_decoder`

## Requirements
- R1: A word address (byte address with bits 1:0 cleared) below 0x40 selects the SCSI core bank; its word index is the byte address shifted right by two.
- R2: A word address from 0x40 to 0x5C selects the DMA bank; its word index is (word address − 0x40) shifted right by two.
- R3: The bus-and-control register is read and written only through the word at 0x70 (byte addresses 0x70–0x73). Full writes to 0x60–0x6F and 0x74–0x7F change no target, and reads there return zero. At most one target write strobe is high in any cycle.
- R4: `host_size` encodes bytes−1 (0 = 1 byte … 3 = 4 bytes). Read data is the target word shifted right by 8×address[1:0], then cut to the access size with the upper bits zero. It appears on `host_rdata` with `host_rvalid` high for one cycle, in the cycle after the read is accepted.
- R5: A 4-byte write at an address with bits 1:0 equal to zero goes to the target in the cycle it is accepted, and `host_ready` stays high.
- R6: Any other write replaces only the addressed bytes, little-endian. Write-data byte k goes to word byte address[1:0]+k, bytes that would fall beyond byte 3 are dropped, and the other bytes of the target word keep their value.
- R7: For a narrow or misaligned write from 0x60 to 0x73, the merge starts from the bus-and-control register value. Only writes that land on the 0x70 word change it.
- R8: The merge fetch raises no target read strobe. A read strobe is high only in the cycle a host read to that bank is accepted.
- R9: After a narrow or misaligned write is accepted, `host_ready` is low for exactly two cycles and the merged write is issued in the second. Requests presented while `host_ready` is low are ignored.
- R10: After reset, `host_ready` is high, `host_rvalid` is low, `host_rdata` is zero and no target strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, taken when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte address in the window |
| host_size | input | 2 | Access size in bytes minus one |
| host_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| host_ready | output | 1 | Block can accept a request |
| host_rvalid | output | 1 | Read data valid (one cycle) |
| host_rdata | output | 32 | Read data, right-aligned |
| core_rd | output | 1 | Read strobe to SCSI core bank (may have side effects) |
| core_wr | output | 1 | Write strobe to SCSI core bank |
| core_idx | output | 4 | SCSI core word index |
| core_rdata | input | 32 | SCSI core word at `core_idx` |
| dma_rd | output | 1 | Read strobe to DMA bank |
| dma_wr | output | 1 | Write strobe to DMA bank |
| dma_idx | output | 3 | DMA word index |
| dma_rdata | input | 32 | DMA word at `dma_idx` |
| ctl_wr | output | 1 | Write strobe to bus-and-control register |
| ctl_rdata | input | 32 | Bus-and-control register value |
| tgt_wdata | output | 32 | Full word written to whichever target is strobed |

## Verification
Read data is due one edge after acceptance, so the bench drives the request on a falling edge and checks `host_rvalid` and `host_rdata` on the next falling edge. A full aligned write reaches the target at the accepting edge. A merged write reaches it two edges later. The bench counts the falling edges with `host_ready` low (expecting 0 or 2) and only then starts the next access. It confirms every write through later reads against its own reference copy of all three targets. Read strobes are counted at rising edges and compared with the number of bank reads issued, which shows that merge fetches stayed silent.

// File: rtl/regwin_pkg.sv
// Shared types and helpers for the sub-word register window decoder.
// Assumes a 32-bit little-endian target word of four byte lanes.
package regwin_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = 8 * WORD_BYTES;

    // Which target an address (or a merge fetch) resolves to.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CORE = 2'd1,
        TGT_DMA  = 2'd2,
        TGT_CTL  = 2'd3
    } tgt_e;

    // Read-merge-write sequencer state.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_ISSUE = 2'd2
    } seq_e;

    // Byte-lane enables for an access of (size_m1 + 1) bytes, unshifted.
    function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [1:0] size_m1);
        logic [WORD_BYTES-1:0] m;
        for (int b = 0; b < WORD_BYTES; b++) begin
            m[b] = (b <= int'(size_m1));
        end
        return m;
    endfunction

endpackage

// File: rtl/regwin_addr_map.sv
// Address map: resolves a byte address to the target used for a word
// access, the target used as the merge source, and each bank's word index.
// Assumes all region bounds are multiples of four bytes.
module regwin_addr_map
    import regwin_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int CORE_END   = 64,
    parameter int DMA_END    = 96,
    parameter int CTL_WORD   = 112,
    parameter int MERGE_HI   = 116,
    parameter int CORE_IDX_W = 4,
    parameter int DMA_IDX_W  = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output tgt_e                  acc_tgt,
    output tgt_e                  mrg_src,
    output logic [CORE_IDX_W-1:0] core_idx,
    output logic [DMA_IDX_W-1:0]  dma_idx
);

    logic [ADDR_W-1:0] word_addr;

    // Purpose: align the address down to its word.
    always_comb begin
        word_addr = {addr[ADDR_W-1:2], 2'b00};
    end

    // Purpose: pick the access target and the merge-source target.
    always_comb begin
        if (int'(word_addr) < CORE_END) begin
            acc_tgt = TGT_CORE;
            mrg_src = TGT_CORE;
        end else if (int'(word_addr) < DMA_END) begin
            acc_tgt = TGT_DMA;
            mrg_src = TGT_DMA;
        end else begin
            acc_tgt = (int'(word_addr) == CTL_WORD) ? TGT_CTL : TGT_NONE;
            mrg_src = (int'(word_addr) < MERGE_HI) ? TGT_CTL : TGT_NONE;
        end
    end

    // Purpose: translate the address into each bank's word index.
    always_comb begin
        core_idx = word_addr[CORE_IDX_W+1:2];
        dma_idx  = DMA_IDX_W'((word_addr - ADDR_W'(CORE_END)) >> 2);
    end

endmodule

// File: rtl/regwin_lanes.sv
// Byte-lane datapath: merges write bytes into a current word and extracts
// read bytes from a target word. Purely combinational; little-endian lanes.
module regwin_lanes
    import regwin_pkg::*;
(
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [1:0]        size_m1,
    input  logic [1:0]        boff,
    output logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] extracted
);

    logic [WORD_BYTES-1:0] lmask;
    logic [WORD_W-1:0]     bmask;
    logic [4:0]            shamt;

    // Purpose: lane enables and bit shift for this access.
    always_comb begin
        lmask = lane_mask(size_m1);
        shamt = {boff, 3'b000};
    end

    // One byte-wide mask slice per lane.
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
        assign bmask[8*b +: 8] = {8{lmask[b]}};
    end

    // Purpose: write merge keeps untouched lanes; read extract right-aligns.
    always_comb begin
        merged    = (cur_word & ~(bmask << shamt)) | ((wdata & bmask) << shamt);
        extracted = (rd_word >> shamt) & bmask;
    end

    // Extract of freshly merged lanes must return the written bytes.
    always_comb begin
        if (rd_word == merged) begin
            p_merge_roundtrip_r6: assert (((extracted ^ wdata) & bmask & ({WORD_W{1'b1}} >> shamt)) == '0);
        end
    end

endmodule

// File: rtl/regwin_seq.sv
// Read-merge-write sequencer: on a narrow or misaligned write it holds the
// request, fetches and merges in one cycle, issues the write in the next.
// Assumes the host only presents requests while ready is high.
module regwin_seq
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_full,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [WORD_W-1:0] merged_in,
    output logic              ready,
    output logic              issue,
    output logic [ADDR_W-1:0] p_addr,
    output logic [1:0]        p_size,
    output logic [WORD_W-1:0] p_wdata,
    output logic [WORD_W-1:0] p_merged
);

    seq_e state;

    assign ready = (state == SQ_IDLE);
    assign issue = (state == SQ_ISSUE);

    // Purpose: step the sequence and hold the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            p_addr   <= '0;
            p_size   <= '0;
            p_wdata  <= '0;
            p_merged <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (host_req && host_we && !host_full) begin
                        p_addr  <= host_addr;
                        p_size  <= host_size;
                        p_wdata <= host_wdata;
                        state   <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    p_merged <= merged_in;
                    state    <= SQ_ISSUE;
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end

    p_fetch_to_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_FETCH) |=> (state == SQ_ISSUE));

    p_issue_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ISSUE) |=> (state == SQ_IDLE));

    p_hold_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_FETCH) |=> $stable(p_addr) && $stable(p_size));

endmodule

// File: rtl/regwin_decoder.sv
// Top of the sub-word register window: routes host accesses to the SCSI
// core bank, the DMA bank or the bus-and-control register, widens narrow
// writes into merged full-word writes, and extracts narrow read data.
// Assumes target read data is combinational on the index, and that only
// the rd strobes (never the index alone) cause target read side effects.
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter  int ADDR_W     = 7,
    parameter  int CORE_END   = 64,
    parameter  int DMA_END    = 96,
    parameter  int CTL_WORD   = 112,
    parameter  int MERGE_HI   = 116,
    localparam int CORE_IDX_W = $clog2(CORE_END / WORD_BYTES),
    localparam int DMA_IDX_W  = $clog2((DMA_END - CORE_END) / WORD_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [1:0]            host_size,
    input  logic [WORD_W-1:0]     host_wdata,
    output logic                  host_ready,
    output logic                  host_rvalid,
    output logic [WORD_W-1:0]     host_rdata,
    output logic                  core_rd,
    output logic                  core_wr,
    output logic [CORE_IDX_W-1:0] core_idx,
    input  logic [WORD_W-1:0]     core_rdata,
    output logic                  dma_rd,
    output logic                  dma_wr,
    output logic [DMA_IDX_W-1:0]  dma_idx,
    input  logic [WORD_W-1:0]     dma_rdata,
    output logic                  ctl_wr,
    input  logic [WORD_W-1:0]     ctl_rdata,
    output logic [WORD_W-1:0]     tgt_wdata
);

    tgt_e              acc_tgt;
    tgt_e              mrg_src;
    logic [ADDR_W-1:0] p_addr, cur_addr;
    logic [1:0]        p_size, cur_size;
    logic [WORD_W-1:0] p_wdata, p_merged, cur_wdata;
    logic [WORD_W-1:0] cur_word, rd_word, merged, extracted;
    logic              issue, accept, rd_acc, full_shape, full_wr, wr_go;

    // Purpose: classify the incoming request.
    always_comb begin
        accept     = host_req && host_ready;
        full_shape = (host_size == 2'b11) && (host_addr[1:0] == 2'b00);
        rd_acc     = accept && !host_we;
        full_wr    = accept && host_we && full_shape;
    end

    // Purpose: while busy, decode from the held request instead of the port.
    always_comb begin
        cur_addr  = host_ready ? host_addr  : p_addr;
        cur_size  = host_ready ? host_size  : p_size;
        cur_wdata = host_ready ? host_wdata : p_wdata;
    end

    regwin_addr_map #(
        .ADDR_W    (ADDR_W),
        .CORE_END  (CORE_END),
        .DMA_END   (DMA_END),
        .CTL_WORD  (CTL_WORD),
        .MERGE_HI  (MERGE_HI),
        .CORE_IDX_W(CORE_IDX_W),
        .DMA_IDX_W (DMA_IDX_W)
    ) u_map (
        .addr    (cur_addr),
        .acc_tgt (acc_tgt),
        .mrg_src (mrg_src),
        .core_idx(core_idx),
        .dma_idx (dma_idx)
    );

    // Purpose: select the merge-source word and the read word.
    always_comb begin
        case (mrg_src)
            TGT_CORE: cur_word = core_rdata;
            TGT_DMA:  cur_word = dma_rdata;
            TGT_CTL:  cur_word = ctl_rdata;
            default:  cur_word = '0;
        endcase
        case (acc_tgt)
            TGT_CORE: rd_word = core_rdata;
            TGT_DMA:  rd_word = dma_rdata;
            TGT_CTL:  rd_word = ctl_rdata;
            default:  rd_word = '0;
        endcase
    end

    regwin_lanes u_lanes (
        .cur_word (cur_word),
        .wdata    (cur_wdata),
        .rd_word  (rd_word),
        .size_m1  (cur_size),
        .boff     (cur_addr[1:0]),
        .merged   (merged),
        .extracted(extracted)
    );

    regwin_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_full (full_shape),
        .host_addr (host_addr),
        .host_size (host_size),
        .host_wdata(host_wdata),
        .merged_in (merged),
        .ready     (host_ready),
        .issue     (issue),
        .p_addr    (p_addr),
        .p_size    (p_size),
        .p_wdata   (p_wdata),
        .p_merged  (p_merged)
    );

    // Purpose: target strobes; reads strobe only on host reads.
    always_comb begin
        wr_go     = full_wr || issue;
        core_wr   = wr_go && (acc_tgt == TGT_CORE);
        dma_wr    = wr_go && (acc_tgt == TGT_DMA);
        ctl_wr    = wr_go && (acc_tgt == TGT_CTL);
        core_rd   = rd_acc && (acc_tgt == TGT_CORE);
        dma_rd    = rd_acc && (acc_tgt == TGT_DMA);
        tgt_wdata = issue ? p_merged : host_wdata;
    end

    // Purpose: register the read response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= rd_acc;
            if (rd_acc) begin
                host_rdata <= extracted;
            end
        end
    end

    p_merge_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |-> !core_rd && !dma_rd);

    p_one_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_wr, dma_wr, ctl_wr}));

    p_rvalid_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_we) |=> host_rvalid);

    p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_ready));

    p_full_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && host_we && full_shape) |=> host_ready);

    p_stall_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |=> !host_ready);

    p_stall_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && $past(!host_ready)) |=> host_ready);

endmodule

// File: tb/regwin_decoder_test.sv
`timescale 1ns/1ps
module regwin_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [31:0] host_rdata;
    logic        core_rd, core_wr, dma_rd, dma_wr, ctl_wr;
    logic [3:0]  core_idx;
    logic [2:0]  dma_idx;
    logic [31:0] core_rdata, dma_rdata, ctl_rdata, tgt_wdata;

    logic [31:0] core_mem [16];
    logic [31:0] dma_mem  [8];
    logic [31:0] ctl_q;
    logic [31:0] ref_core [16];
    logic [31:0] ref_dma  [8];
    logic [31:0] ref_ctl;

    int total = 0;
    int bad = 0;
    int n_core_rd = 0, n_dma_rd = 0;
    int exp_core_rd = 0, exp_dma_rd = 0;

    always #2.5 clk = ~clk;

    regwin_decoder uut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .core_rd(core_rd), .core_wr(core_wr), .core_idx(core_idx), .core_rdata(core_rdata),
        .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_idx(dma_idx), .dma_rdata(dma_rdata),
        .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata), .tgt_wdata(tgt_wdata)
    );

    // Target models: combinational read, write at the clock edge.
    assign core_rdata = core_mem[core_idx];
    assign dma_rdata  = dma_mem[dma_idx];
    assign ctl_rdata  = ctl_q;

    always @(posedge clk) begin
        if (core_wr) core_mem[core_idx] <= tgt_wdata;
        if (dma_wr)  dma_mem[dma_idx]   <= tgt_wdata;
        if (ctl_wr)  ctl_q              <= tgt_wdata;
        if (core_rd) n_core_rd++;
        if (dma_rd)  n_dma_rd++;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input int a);
        int w = a & ~3;
        if (w < 'h40) return ref_core[w >> 2];
        if (w < 'h60) return ref_dma[(w - 'h40) >> 2];
        if (w == 'h70) return ref_ctl;
        return 32'h0;
    endfunction

    function automatic logic [31:0] ref_cur(input int a);
        if (a < 'h60) return ref_word(a);
        if (a < 'h74) return ref_ctl;
        return 32'h0;
    endfunction

    function automatic void ref_store(input int a, input logic [31:0] v);
        int w = a & ~3;
        if (w < 'h40) ref_core[w >> 2] = v;
        else if (w < 'h60) ref_dma[(w - 'h40) >> 2] = v;
        else if (w == 'h70) ref_ctl = v;
    endfunction

    function automatic logic [31:0] merge_fn(input logic [31:0] cur, input logic [31:0] wd, input int nb, input int off);
        logic [31:0] r;
        r = cur;
        for (int k = 0; k < nb; k++) begin
            if (off + k < 4) r[8*(off+k) +: 8] = wd[8*k +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] extract_fn(input logic [31:0] w, input int nb, input int off);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < nb; k++) begin
            if (off + k < 4) r[8*k +: 8] = w[8*(off+k) +: 8];
        end
        return r;
    endfunction

    function automatic string region_tag(input int a);
        if (a < 'h40) return "R1";
        if (a < 'h60) return "R2";
        return "R3";
    endfunction

    // Write: starts and ends at a falling edge; checks the stall length.
    task automatic do_write(input int a, input int nb, input logic [31:0] wd, input string tag);
        bit full;
        int busy;
        logic [31:0] nv;
        full = (nb == 4) && ((a & 3) == 0);
        nv = full ? wd : merge_fn(ref_cur(a), wd, nb, a & 3);
        host_req = 1'b1; host_we = 1'b1; host_addr = 7'(a);
        host_size = 2'(nb - 1); host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        busy = 0;
        while (!host_ready && busy < 10) begin
            busy++;
            @(negedge clk);
        end
        check(busy == (full ? 0 : 2), full ? "R5 stall" : "R9 stall", 32'(busy), full ? 32'd0 : 32'd2);
        ref_store(a, nv);
        if (tag.len() > 0) begin end
    endtask

    // Read: data due at the next falling edge after acceptance.
    task automatic do_read(input int a, input int nb, input string tag);
        logic [31:0] exp;
        exp = extract_fn(ref_word(a), nb, a & 3);
        host_req = 1'b1; host_we = 1'b0; host_addr = 7'(a);
        host_size = 2'(nb - 1); host_wdata = $urandom;
        if ((a & ~3) < 'h40) exp_core_rd++;
        else if ((a & ~3) < 'h60) exp_dma_rd++;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        check(host_rvalid == 1'b1, {tag, " R4 rvalid"}, 32'(host_rvalid), 32'd1);
        check(host_rdata == exp, {tag, " R4 data"}, host_rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 16; i++) begin core_mem[i] = '0; ref_core[i] = '0; end
        for (int i = 0; i < 8; i++) begin dma_mem[i] = '0; ref_dma[i] = '0; end
        ctl_q = '0; ref_ctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check(host_ready == 1'b1, "R10 ready", 32'(host_ready), 32'd1);
        check(host_rvalid == 1'b0, "R10 rvalid", 32'(host_rvalid), 32'd0);
        check(host_rdata == 32'h0, "R10 rdata", host_rdata, 32'h0);
        check({core_rd, core_wr, dma_rd, dma_wr, ctl_wr} == 5'b0, "R10 strobes",
              32'({core_rd, core_wr, dma_rd, dma_wr, ctl_wr}), 32'd0);

        // R1 R2 R3 R5: fill every word with full aligned writes
        for (int a = 0; a < 'h60; a += 4) do_write(a, 4, $urandom, "R5");
        do_write('h70, 4, 32'hA5C3_0F17, "R3");
        do_write('h60, 4, 32'h1111_2222, "R3");
        do_write('h74, 4, 32'h3333_4444, "R3");
        do_write('h7C, 4, 32'h5555_6666, "R3");
        for (int a = 0; a < 'h80; a += 4) do_read(a, 4, region_tag(a));

        // R4: narrow reads at every lane offset
        do_read('h43, 1, "R4");
        do_read('h06, 2, "R4");
        do_read('h1D, 3, "R4");
        do_read('h72, 4, "R4");
        do_read('h6A, 2, "R3");

        // R6: narrow and misaligned merges
        do_write('h09, 1, 32'hFFFF_FF5A, "R6");
        do_read('h08, 4, "R6");
        do_write('h05, 3, 32'hFFC0_FFEE, "R6");
        do_read('h04, 4, "R6");
        do_write('h4A, 4, 32'h89AB_CDEF, "R6");
        do_read('h48, 4, "R6");
        do_write('h3F, 2, 32'h0000_7E7E, "R6");
        do_read('h3C, 4, "R6");

        // R7: merges against the bus-and-control register
        do_write('h71, 1, 32'h0000_00B4, "R7");
        do_read('h70, 4, "R7");
        do_write('h62, 2, 32'h0000_DEAD, "R7");
        do_read('h70, 4, "R7");
        do_read('h60, 4, "R7");

        // R9: request during the stall is ignored
        host_req = 1'b1; host_we = 1'b1; host_addr = 7'h0A;
        host_size = 2'd0; host_wdata = 32'h0000_0077;
        @(posedge clk);
        @(negedge clk);
        check(host_ready == 1'b0, "R9 busy1", 32'(host_ready), 32'd0);
        host_req = 1'b1; host_we = 1'b1; host_addr = 7'h00;
        host_size = 2'd3; host_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        host_req = 1'b0;
        check(host_ready == 1'b0, "R9 busy2", 32'(host_ready), 32'd0);
        @(negedge clk);
        check(host_ready == 1'b1, "R9 done", 32'(host_ready), 32'd1);
        ref_store('h08, merge_fn(ref_cur('h0A), 32'h77, 1, 2));
        do_read('h00, 4, "R9");
        do_read('h08, 4, "R9");

        // R8: merges so far raised no read strobes
        check(n_core_rd == exp_core_rd, "R8 core strobes", 32'(n_core_rd), 32'(exp_core_rd));
        check(n_dma_rd == exp_dma_rd, "R8 dma strobes", 32'(n_dma_rd), 32'(exp_dma_rd));

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int a, nb;
            a  = int'($urandom_range(0, 127));
            nb = int'($urandom_range(1, 4));
            if ($urandom_range(0, 1) == 1) do_write(a, nb, $urandom, "R6");
            else do_read(a, nb, region_tag(a));
        end
        for (int a = 0; a < 'h80; a += 4) do_read(a, 4, region_tag(a));

        check(n_core_rd == exp_core_rd, "R8 core strobes end", 32'(n_core_rd), 32'(exp_core_rd));
        check(n_dma_rd == exp_dma_rd, "R8 dma strobes end", 32'(n_dma_rd), 32'(exp_dma_rd));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule